// File: doc/BRIEF.md
# Ancillary Packet Checksum Corrector

This block sits in a 10-bit video word stream and looks for ancillary data packets. A packet opens with the three-word flag 000h, 3FFh, 3FFh. The flag is followed by an identifier word, a secondary identifier/block-number word, a data count word, as many user words as the count gives, and then one checksum word. As the packet passes, the block adds bits 8:0 of every word from the identifier through the last user word into a 9-bit sum. When the checksum word arrives, the block can replace it with the recomputed value.

Replacement happens only when all three controls agree: the processing enable is high, the formatting-path enable is high, and the active-low insertion control is low. An incoming checksum whose value lies in either of the two reserved bands is always passed through unchanged. No other word is ever altered. The input and the output are valid/ready streams. Every accepted word leaves through a single output register, so each word's latency is one accepted transfer. The block has no internal buffer of its own beyond that register.

Back-pressure rules: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held and no input is taken.

Top module: `anc_csum_fix`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable and `in_ready` is low.
- R3: A word accepted on `in_valid && in_ready` appears on `out_data` with `out_valid` high in the next cycle.
- R4: Every word that is not a packet's checksum word (flag words, header words, user words and words outside packets) leaves the block unchanged.
- R5: When insertion is enabled, the checksum word is replaced by {~s[8], s[8:0]}. Here s is the 9-bit modulo-512 sum of bits 8:0 of the identifier, secondary identifier, data count and all user words.
- R6: If `proc_en` is low, or `fmt_path_en` is low, or `csum_ins_n` is high, the checksum word leaves unchanged.
- R7: An incoming checksum word in the range 000h to 003h leaves unchanged, even when insertion is enabled.
- R8: An incoming checksum word in the range 3FCh to 3FFh leaves unchanged, even when insertion is enabled.
- R9: Only bits 7:0 of the data count word set the number of user words. Counts of 0, where the checksum follows the data count directly, and 255 are both handled; bits 9:8 of the count word do not change the length.
- R10: A complete flag 000h, 3FFh, 3FFh seen inside a packet restarts parsing at the next word. The interrupted packet is never corrected, and the following packet is parsed and corrected on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 10 | Incoming video word |
| in_valid | input | 1 | Incoming word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| out_data | output | 10 | Outgoing, possibly corrected, word |
| out_valid | output | 1 | Outgoing word is valid |
| out_ready | input | 1 | Downstream takes the outgoing word |
| proc_en | input | 1 | Processing enable, high to allow correction |
| fmt_path_en | input | 1 | Formatting-path enable, high to allow correction |
| csum_ins_n | input | 1 | Checksum insertion control, low to allow correction |

## Verification
The hardest case to reach from the ports is a packet cut short by a new flag. In that case, parsing must restart at exactly the word where the old packet's count would have ended. The stimulus declares five user words, sends two, and then sends the three flag words. The final 3FFh therefore lands where the checksum counter expires, and the identifier of the next packet arrives where a broken parser would expect the checksum, so a wrongly corrected identifier shows up as a mismatch. Random output stalls are also applied across whole packets, so that parsing is seen to advance only on accepted transfers.

// File: rtl/anc_csum_pkg.sv
package anc_csum_pkg;

  // Parser position inside an ancillary packet
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_ID,
    ST_SUBID,
    ST_COUNT,
    ST_USER,
    ST_SUM
  } anc_state_e;

endpackage

// File: rtl/anc_adf_watch.sv
// Tracks the last two accepted words and flags completion of the
// 000h / all-ones / all-ones opening sequence on the current word.
module anc_adf_watch #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [DATA_W-1:0] word,
  output logic              flag_hit
);
  localparam logic [DATA_W-1:0] ALL1 = '1;
  localparam logic [DATA_W-1:0] ALL0 = '0;

  logic [DATA_W-1:0] prev1, prev2;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev1 <= ALL1;
      prev2 <= ALL1;
    end else if (step) begin
      prev1 <= word;
      prev2 <= prev1;
    end
  end

  assign flag_hit = (prev2 == ALL0) && (prev1 == ALL1) && (word == ALL1);
endmodule

// File: rtl/anc_parse.sv
// Walks the packet header and user words, keeps the running sum and
// marks the word that sits in the checksum position.
module anc_parse
  import anc_csum_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [DATA_W-1:0] word,
  input  logic              flag_hit,
  output logic              at_sum,
  output logic [DATA_W-2:0] sum_q
);
  localparam int SUM_W = DATA_W - 1;

  anc_state_e       state;
  logic [CNT_W-1:0] left;
  logic [SUM_W-1:0] add_term;

  assign add_term = word[SUM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      left  <= '0;
      sum_q <= '0;
    end else if (step) begin
      if (flag_hit) begin
        state <= ST_ID;
      end else begin
        unique case (state)
          ST_HUNT: state <= ST_HUNT;
          ST_ID: begin
            sum_q <= add_term;
            state <= ST_SUBID;
          end
          ST_SUBID: begin
            sum_q <= sum_q + add_term;
            state <= ST_COUNT;
          end
          ST_COUNT: begin
            sum_q <= sum_q + add_term;
            left  <= word[CNT_W-1:0];
            state <= (word[CNT_W-1:0] == '0) ? ST_SUM : ST_USER;
          end
          ST_USER: begin
            sum_q <= sum_q + add_term;
            left  <= left - CNT_W'(1);
            if (left == CNT_W'(1)) state <= ST_SUM;
          end
          ST_SUM:  state <= ST_HUNT;
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign at_sum = (state == ST_SUM) && !flag_hit;
endmodule

// File: rtl/anc_pipe_reg.sv
// Single valid/ready register stage; accepts whenever empty or draining.
module anc_pipe_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic         r_in,
  output logic [W-1:0] d_out,
  output logic         v_out,
  input  logic         r_out
);
  assign r_in = !v_out || r_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      d_out <= '0;
    end else if (v_in && r_in) begin
      v_out <= 1'b1;
      d_out <= d_in;
    end else if (r_out) begin
      v_out <= 1'b0;
    end
  end
endmodule

// File: rtl/anc_csum_fix.sv
module anc_csum_fix #(
  parameter int DATA_W    = 10,
  parameter int CNT_W     = 8,
  parameter int PROT_SPAN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              proc_en,
  input  logic              fmt_path_en,
  input  logic              csum_ins_n
);
  localparam int SUM_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] ALL1   = '1;
  localparam logic [DATA_W-1:0] LO_LIM = DATA_W'(PROT_SPAN);
  localparam logic [DATA_W-1:0] HI_LIM = ALL1 - LO_LIM + DATA_W'(1);

  logic              step;
  logic              flag_hit;
  logic              at_sum;
  logic [SUM_W-1:0]  sum_q;
  logic              ins_en;
  logic              reserved;
  logic [DATA_W-1:0] fixed_word;
  logic [DATA_W-1:0] next_word;

  assign step = in_valid && in_ready;

  anc_adf_watch #(.DATA_W(DATA_W)) u_watch (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .word     (in_data),
    .flag_hit (flag_hit)
  );

  anc_parse #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_parse (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .word     (in_data),
    .flag_hit (flag_hit),
    .at_sum   (at_sum),
    .sum_q    (sum_q)
  );

  assign ins_en     = proc_en && fmt_path_en && !csum_ins_n;
  assign reserved   = (in_data < LO_LIM) || (in_data >= HI_LIM);
  assign fixed_word = {~sum_q[SUM_W-1], sum_q};
  assign next_word  = (at_sum && ins_en && !reserved) ? fixed_word : in_data;

  anc_pipe_reg #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .d_in  (next_word),
    .v_in  (in_valid),
    .r_in  (in_ready),
    .d_out (out_data),
    .v_out (out_valid),
    .r_out (out_ready)
  );
endmodule

// File: rtl/anc_csum_fix_chk.sv
module anc_csum_fix_chk #(
  parameter int DATA_W    = 10,
  parameter int PROT_SPAN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              proc_en,
  input logic              fmt_path_en,
  input logic              csum_ins_n
);
  localparam logic [DATA_W-1:0] ALL1   = '1;
  localparam logic [DATA_W-1:0] LO_LIM = DATA_W'(PROT_SPAN);
  localparam logic [DATA_W-1:0] HI_LIM = ALL1 - LO_LIM + DATA_W'(1);

  logic acc;
  assign acc = in_valid && in_ready;

  p_rst_empty_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && !(proc_en && fmt_path_en && !csum_ins_n)) |=> (out_data == $past(in_data)));

  p_low_band_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && (in_data < LO_LIM)) |=> (out_data == $past(in_data)));

  p_high_band_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && (in_data >= HI_LIM)) |=> (out_data == $past(in_data)));
endmodule

bind anc_csum_fix anc_csum_fix_chk #(.DATA_W(DATA_W), .PROT_SPAN(PROT_SPAN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_data     (in_data),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .proc_en     (proc_en),
  .fmt_path_en (fmt_path_en),
  .csum_ins_n  (csum_ins_n)
);

// File: tb/anc_csum_fix_bench.sv
`timescale 1ns/1ps
module anc_csum_fix_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       proc_en = 1'b1;
  logic       fmt_path_en = 1'b1;
  logic       csum_ins_n = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] exp_q [0:4095];
  string      tag_q [0:4095];
  int wr_p = 0;
  int rd_p = 0;

  bit          stall_rand = 0;
  bit          hold_rdy = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  anc_csum_fix u_anc_csum_fix (
    .clk         (clk),
    .rst         (rst),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .proc_en     (proc_en),
    .fmt_path_en (fmt_path_en),
    .csum_ins_n  (csum_ins_n)
  );

  // downstream ready generator
  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_rand ? lfsr[0] : !hold_rdy;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %03h expected %03h", req, act, expv);
    end
  endtask

  // output collector: compares every word taken downstream
  always begin
    @(negedge clk);
    #1;
    if (!rst && out_valid && out_ready) begin
      if (rd_p == wr_p) check(1'b0, "R4 unexpected word", int'(out_data), 0);
      else begin
        check(out_data == exp_q[rd_p], tag_q[rd_p], int'(out_data), int'(exp_q[rd_p]));
        rd_p++;
      end
    end
  end

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    report();
  end

  task automatic push(input logic [9:0] e, input string tag);
    exp_q[wr_p] = e;
    tag_q[wr_p] = tag;
    wr_p++;
  endtask

  task automatic drive(input logic [9:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [9:0] w, input logic [9:0] e, input string tag);
    push(e, tag);
    drive(w);
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain;
    idle();
    for (int i = 0; i < 2000 && rd_p != wr_p; i++) @(negedge clk);
    check(rd_p == wr_p, "R4 drain", rd_p, wr_p);
  endtask

  function automatic logic [9:0] user_word(input int k, input logic [9:0] seed);
    return 10'h100 | 10'((k * 29 + int'(seed)) & 8'hFF);
  endfunction

  // full packet: flag, header, user words, checksum; expected from the requirements
  task automatic packet(input logic [9:0] id, input logic [9:0] subid, input logic [9:0] cnt_w,
                        input logic [9:0] cs_in, input string tag);
    logic [8:0] s;
    logic [9:0] uw;
    bit en;
    en = proc_en && fmt_path_en && !csum_ins_n;
    send(10'h000, 10'h000, "R4 flag");
    send(10'h3FF, 10'h3FF, "R4 flag");
    send(10'h3FF, 10'h3FF, "R4 flag");
    s = id[8:0] + subid[8:0] + cnt_w[8:0];
    send(id, id, "R4 id");
    send(subid, subid, "R4 subid");
    send(cnt_w, cnt_w, "R9 count word");
    for (int k = 0; k < int'(cnt_w[7:0]); k++) begin
      uw = user_word(k, id);
      s  = s + uw[8:0];
      send(uw, uw, "R4 user word");
    end
    if (en && cs_in > 10'h003 && cs_in < 10'h3FC) send(cs_in, {~s[8], s}, tag);
    else send(cs_in, cs_in, tag);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_plain;
    for (int i = 0; i < 6; i++) begin
      logic [9:0] w;
      w = 10'(i * 97 + 5);
      send(w, w, "R4 plain word");
      @(negedge clk); #1;
      check(out_valid && out_data == w, "R3 one-cycle latency", int'(out_data), int'(w));
      in_valid = 1'b0;
    end
    drain();
  endtask

  task automatic t_basic;
    packet(10'h241, 10'h101, 10'h203, 10'h155, "R5 checksum small");
    packet(10'h160, 10'h160, 10'h110, 10'h200, "R5 checksum 16 words");
    packet(10'h2FF, 10'h1FE, 10'h207, 10'h004, "R5 checksum just above low band");
    packet(10'h2AA, 10'h155, 10'h102, 10'h3FB, "R5 checksum just below high band");
    drain();
  endtask

  task automatic t_gate;
    proc_en = 1'b0;
    packet(10'h241, 10'h101, 10'h203, 10'h155, "R6 proc_en low");
    idle();
    proc_en = 1'b1;
    fmt_path_en = 1'b0;
    packet(10'h241, 10'h101, 10'h203, 10'h155, "R6 fmt_path_en low");
    idle();
    fmt_path_en = 1'b1;
    csum_ins_n = 1'b1;
    packet(10'h241, 10'h101, 10'h203, 10'h155, "R6 csum_ins_n high");
    idle();
    csum_ins_n = 1'b0;
    drain();
  endtask

  task automatic t_bands;
    packet(10'h241, 10'h101, 10'h203, 10'h000, "R7 band 000");
    packet(10'h241, 10'h101, 10'h203, 10'h003, "R7 band 003");
    packet(10'h241, 10'h101, 10'h203, 10'h3FC, "R8 band 3FC");
    packet(10'h241, 10'h101, 10'h203, 10'h3FF, "R8 band 3FF");
    drain();
  endtask

  task automatic t_count_edges;
    packet(10'h241, 10'h101, 10'h200, 10'h123, "R9 count zero");
    packet(10'h241, 10'h101, 10'h300, 10'h123, "R9 count zero, high bits set");
    packet(10'h161, 10'h101, 10'h2FF, 10'h123, "R9 count 255");
    drain();
  endtask

  task automatic t_restart;
    // 5 user words declared, 2 sent, then a new flag whose last word lands
    // where the old count would expire
    send(10'h000, 10'h000, "R10 flag");
    send(10'h3FF, 10'h3FF, "R10 flag");
    send(10'h3FF, 10'h3FF, "R10 flag");
    send(10'h250, 10'h250, "R10 partial id");
    send(10'h101, 10'h101, "R10 partial subid");
    send(10'h105, 10'h105, "R10 partial count");
    send(10'h111, 10'h111, "R10 partial user");
    send(10'h122, 10'h122, "R10 partial user");
    packet(10'h1A5, 10'h102, 10'h104, 10'h2A0, "R10 packet after restart");
    drain();
  endtask

  task automatic t_backpressure;
    hold_rdy = 1'b1;
    @(negedge clk);
    send(10'h0AB, 10'h0AB, "R2 held word");
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'h0CD;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(in_ready == 1'b0, "R2 in_ready low in stall", in_ready, 0);
      check(out_valid && out_data == 10'h0AB, "R2 output held", int'(out_data), 10'h0AB);
      @(negedge clk);
    end
    hold_rdy = 1'b0;
    push(10'h0CD, "R2 word after stall");
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    stall_rand = 1'b1;
    packet(10'h241, 10'h101, 10'h206, 10'h155, "R2 checksum under stalls");
    packet(10'h3A0, 10'h1C1, 10'h200, 10'h2EE, "R2 zero count under stalls");
    drain();
    stall_rand = 1'b0;
  endtask

  initial begin
    t_reset();
    t_plain();
    t_basic();
    t_gate();
    t_bands();
    t_count_edges();
    t_restart();
    t_backpressure();
    repeat (4) @(negedge clk);
    report();
  end
endmodule